// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters and a shift register holding the directions of recent branches. The table row for a branch is picked by XORing the word address of the branch with that history. The same branch therefore lands on different counters depending on the path that led to it. A fetch stage sends a program counter on the predict port. One cycle later it gets a direction and the history value that was used to form the index.

The speculative history shifts in each predicted direction as soon as that direction is known. When the branch resolves, the back end sends the program counter, the real outcome, the earlier guess and the history snapshot on the update port. The addressed counter then moves one step toward the real outcome. If the guess was wrong, the history is rebuilt from the snapshot followed by the real outcome. After reset, the table is cleared by a sweep that writes one row per cycle. The block accepts requests only once that sweep has finished.

Top module: `gxp_predictor`

## Requirements
- R1: After reset, `pred_out_valid` is low and the history is all zeros. Every counter starts at weakly-not-taken (binary 01), so the first prediction after `ready` is not taken and carries a snapshot of zero.
- R2: A taken update raises a counter by one and a not-taken update lowers it by one. The counter stops at 00 and at 11 and never wraps.
- R3: The prediction is bit 1 of the addressed counter (1 = taken). A counter at 11 needs two not-taken updates in a row before it predicts not taken.
- R4: The row index is `pc[IDX_W+1:2]` XOR the history, with the history zero-extended to `IDX_W` bits. The same PC with a different history reads a different counter.
- R5: PC bits 1 and 0 have no effect on the row that is chosen.
- R6: A predict request accepted in cycle t gives `pred_out_valid`, `pred_taken` and `pred_hist` in cycle t+1. `pred_hist` is the history used for the index. The history then shifts left with the predicted direction entering bit 0, and a predict request in cycle t+1 already uses this shifted history.
- R7: An update whose `upd_pred` differs from `upd_taken` sets the history to `{upd_hist[HIST_W-2:0], upd_taken}`. An update whose `upd_pred` matches `upd_taken` leaves the history unchanged. An update trains the row given by `upd_pc` XOR `upd_hist`.
- R8: A predict request to the row being trained, issued in the same cycle as the update or in the cycle after it, returns the counter value from before the update. A request issued two or more cycles after the update sees the new value.
- R9: When a mispredicted update and a predict request arrive in the same cycle, the prediction uses the rebuilt history.
- R10: Updates to the same row in consecutive cycles all take effect, each building on the previous one.
- R11: For the 2^IDX_W cycles after reset, `ready` is low and predict and update requests are ignored. `ready` then stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | output | 1 | Table clearing finished; requests are accepted |
| pred_valid | input | 1 | Predict request |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_out_valid | output | 1 | Prediction result is present this cycle |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used to index this prediction |
| upd_valid | input | 1 | Resolved-branch update |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History snapshot returned with its prediction |
| upd_taken | input | 1 | Actual direction |
| upd_pred | input | 1 | Direction that was predicted |

## Verification
The counter is trained with runs of taken and not-taken outcomes that push it past both limits, which separates saturation from wrap-around and one-step hysteresis from two-step hysteresis. The same PC is queried under two histories, and with its low two bits changed, to show that the XOR index really depends on history and not on byte offset. Timing collisions are covered by three patterns: predicts issued back to back, a predict in the same cycle as an update to the same row, and a repair arriving together with a predict. These tell correct history forwarding and read-before-write ordering apart from stale reads. Three updates to one row on consecutive cycles expose a missing write-to-read forward in the training path.

// File: rtl/gxp_pkg.sv
package gxp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MIN     = 2'b00;
  localparam ctr_t CTR_MAX     = 2'b11;

  // one saturating step toward the resolved direction
  function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
    ctr_t nxt;
    nxt = cur;
    if (up && (cur != CTR_MAX))
      nxt = cur + 2'b01;
    else if (!up && (cur != CTR_MIN))
      nxt = cur - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/gxp_ctr_ram.sv
// One write port, two synchronous read ports, read-before-write.
module gxp_ctr_ram #(
  parameter int AW = 10,
  parameter int DW = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_a <= mem[ra_a];
    rd_b <= mem[ra_b];
  end
endmodule

// File: rtl/gxp_sweep.sv
// Walks every row once after reset, writing the initial counter value.
module gxp_sweep #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic          done,
  output logic          we,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '1) done <= 1'b1;
    end
  end

  assign we   = !done;
  assign addr = cnt_q;
endmodule

// File: rtl/gxp_ghist.sv
// Global direction history with speculative shift and repair.
module gxp_ghist #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spec_en,
  input  logic              spec_dir,
  input  logic              fix_en,
  input  logic [HIST_W-1:0] fix_base,
  input  logic              fix_dir,
  output logic [HIST_W-1:0] hist_now
);
  logic [HIST_W-1:0] ghr_q;

  // repair outranks the speculative shift of the previous prediction
  always_comb begin
    if (fix_en)
      hist_now = HIST_W'({fix_base, fix_dir});
    else if (spec_en)
      hist_now = HIST_W'({ghr_q, spec_dir});
    else
      hist_now = ghr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ghr_q <= '0;
    else     ghr_q <= hist_now;
  end
endmodule

// File: rtl/gxp_train.sv
// Two-stage read-modify-write of one counter per update.
module gxp_train import gxp_pkg::*; #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_en,
  input  logic [AW-1:0] in_idx,
  input  logic          in_dir,
  input  ctr_t          rd_base,
  output logic          we,
  output logic [AW-1:0] wa,
  output ctr_t          wd
);
  logic          s1_en_q;
  logic [AW-1:0] s1_idx_q;
  logic          s1_dir_q;
  logic          lw_en_q;
  logic [AW-1:0] lw_idx_q;
  ctr_t          lw_data_q;
  ctr_t          base;

  // the row read one cycle ago misses a write made in that same cycle
  always_comb begin
    if (lw_en_q && (lw_idx_q == s1_idx_q)) base = lw_data_q;
    else                                   base = rd_base;
  end

  assign we = s1_en_q;
  assign wa = s1_idx_q;
  assign wd = ctr_step(base, s1_dir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_en_q <= 1'b0;
      lw_en_q <= 1'b0;
    end else begin
      s1_en_q <= in_en;
      lw_en_q <= s1_en_q;
    end
    s1_idx_q  <= in_idx;
    s1_dir_q  <= in_dir;
    lw_idx_q  <= s1_idx_q;
    lw_data_q <= wd;
  end
endmodule

// File: rtl/gxp_predictor.sv
module gxp_predictor import gxp_pkg::*; #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ready,
  input  logic              pred_valid,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_out_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken,
  input  logic              upd_pred
);
  localparam int PC_LSB = 2;
  localparam int PC_MSB = IDX_W + PC_LSB - 1;

  logic              pv, uv, fix_en;
  logic [HIST_W-1:0] hist_now;
  logic [IDX_W-1:0]  idx_p, idx_u;
  ctr_t              rd_a, rd_b;
  logic              sw_we, tr_we, ram_we;
  logic [IDX_W-1:0]  sw_addr, tr_wa, ram_wa;
  ctr_t              tr_wd, ram_wd;

  assign pv     = pred_valid && ready;
  assign uv     = upd_valid && ready;
  assign fix_en = uv && (upd_pred != upd_taken);

  gxp_sweep #(.AW(IDX_W)) u_sweep (
    .clk  (clk),
    .rst  (rst),
    .done (ready),
    .we   (sw_we),
    .addr (sw_addr)
  );

  gxp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .spec_en  (pred_out_valid),
    .spec_dir (rd_a[1]),
    .fix_en   (fix_en),
    .fix_base (upd_hist),
    .fix_dir  (upd_taken),
    .hist_now (hist_now)
  );

  assign idx_p = pred_pc[PC_MSB:PC_LSB] ^ IDX_W'(hist_now);
  assign idx_u = upd_pc[PC_MSB:PC_LSB]  ^ IDX_W'(upd_hist);

  gxp_train #(.AW(IDX_W)) u_train (
    .clk     (clk),
    .rst     (rst),
    .in_en   (uv),
    .in_idx  (idx_u),
    .in_dir  (upd_taken),
    .rd_base (rd_b),
    .we      (tr_we),
    .wa      (tr_wa),
    .wd      (tr_wd)
  );

  assign ram_we = sw_we | tr_we;
  assign ram_wa = sw_we ? sw_addr : tr_wa;
  assign ram_wd = sw_we ? CTR_WEAK_NT : tr_wd;

  gxp_ctr_ram #(.AW(IDX_W), .DW(2)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .wa   (ram_wa),
    .wd   (ram_wd),
    .ra_a (idx_p),
    .rd_a (rd_a),
    .ra_b (idx_u),
    .rd_b (rd_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_out_valid <= 1'b0;
      pred_hist      <= '0;
    end else begin
      pred_out_valid <= pv;
      if (pv) pred_hist <= hist_now;
    end
  end

  assign pred_taken = rd_a[1];

  logic unused_bits;
  assign unused_bits = ^{rd_a[0], pred_pc[PC_W-1:PC_MSB+1], pred_pc[PC_LSB-1:0],
                         upd_pc[PC_W-1:PC_MSB+1], upd_pc[PC_LSB-1:0]};
endmodule

// File: rtl/gxp_predictor_chk.sv
module gxp_predictor_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic              pred_valid,
  input logic              pred_out_valid,
  input logic              pred_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic              upd_valid,
  input logic [HIST_W-1:0] upd_hist,
  input logic              upd_taken,
  input logic              upd_pred
);
  // R6: an accepted request yields a result next cycle
  a_r6_result_follows: assert property (@(posedge clk) disable iff (rst)
    (ready && pred_valid) |=> pred_out_valid);

  // R11: nothing comes out without an accepted request
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!ready || !pred_valid) |=> !pred_out_valid);

  // R11: ready holds once reached
  a_r11_ready_holds: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R6: back-to-back predictions see the earlier guess shifted in
  a_r6_spec_shift: assert property (@(posedge clk) disable iff (rst)
    (ready && pred_valid && pred_out_valid && !(upd_valid && (upd_pred != upd_taken)))
    |=> (pred_hist == HIST_W'({$past(pred_hist), $past(pred_taken)})));

  // R9: a prediction beside a repair uses the rebuilt history
  a_r9_repair_wins: assert property (@(posedge clk) disable iff (rst)
    (ready && pred_valid && upd_valid && (upd_pred != upd_taken))
    |=> (pred_hist == HIST_W'({$past(upd_hist), $past(upd_taken)})));
endmodule

bind gxp_predictor gxp_predictor_chk #(.HIST_W(HIST_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ready          (ready),
  .pred_valid     (pred_valid),
  .pred_out_valid (pred_out_valid),
  .pred_taken     (pred_taken),
  .pred_hist      (pred_hist),
  .upd_valid      (upd_valid),
  .upd_hist       (upd_hist),
  .upd_taken      (upd_taken),
  .upd_pred       (upd_pred)
);

// File: tb/gxp_predictor_tb.sv
module gxp_predictor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 10;
  localparam int HIST_W = 8;
  localparam int DEPTH  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              ready;
  logic              pred_valid;
  logic [PC_W-1:0]   pred_pc;
  logic              pred_out_valid;
  logic              pred_taken;
  logic [HIST_W-1:0] pred_hist;
  logic              upd_valid;
  logic [PC_W-1:0]   upd_pc;
  logic [HIST_W-1:0] upd_hist;
  logic              upd_taken;
  logic              upd_pred;

  int checks = 0;
  int fails  = 0;

  logic [1:0]        mdl [DEPTH];
  logic [HIST_W-1:0] mghr;

  always #(CLK_PERIOD/2) clk = ~clk;

  gxp_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_dut (
    .clk(clk), .rst(rst), .ready(ready),
    .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_out_valid(pred_out_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist),
    .upd_taken(upd_taken), .upd_pred(upd_pred)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] step(input logic [1:0] c, input logic up);
    if (up)  return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc,
                                               input logic [HIST_W-1:0] h);
    return pc[IDX_W+1:2] ^ IDX_W'(h);
  endfunction

  function automatic logic [PC_W-1:0] pc_for(input logic [IDX_W-1:0] idx,
                                             input logic [HIST_W-1:0] h);
    return PC_W'({idx ^ IDX_W'(h), 2'b00});
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_predict_pc(input logic [PC_W-1:0] pc, input string req);
    logic [IDX_W-1:0] idx;
    logic             exp_t;
    idx   = idx_of(pc, mghr);
    exp_t = mdl[idx][1];
    pred_valid = 1'b1;
    pred_pc    = pc;
    @(negedge clk);
    pred_valid = 1'b0;
    check(req, "pred_out_valid", 32'(pred_out_valid), 32'd1);
    check(req, "pred_taken", 32'(pred_taken), 32'(exp_t));
    check(req, "pred_hist", 32'(pred_hist), 32'(mghr));
    mghr = {mghr[HIST_W-2:0], exp_t};
    idle(2);
  endtask

  task automatic do_predict(input logic [IDX_W-1:0] idx, input string req);
    do_predict_pc(pc_for(idx, mghr), req);
  endtask

  task automatic do_update(input logic [IDX_W-1:0] idx, input logic dir,
                           input logic guess, input logic [HIST_W-1:0] h);
    upd_valid = 1'b1;
    upd_pc    = pc_for(idx, h);
    upd_hist  = h;
    upd_taken = dir;
    upd_pred  = guess;
    @(negedge clk);
    upd_valid = 1'b0;
    mdl[idx] = step(mdl[idx], dir);
    if (guess != dir) mghr = {h[HIST_W-2:0], dir};
    idle(2);
  endtask

  task automatic set_ghr(input logic [HIST_W-1:0] v);
    do_update(IDX_W'(1000), v[0], ~v[0], v >> 1);
  endtask

  // R1, R11
  task automatic t_reset;
    rst = 1'b1;
    idle(3);
    check("R1", "pred_out_valid in reset", 32'(pred_out_valid), 32'd0);
    check("R11", "ready in reset", 32'(ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    pred_valid = 1'b1;
    pred_pc    = '0;
    upd_valid  = 1'b1;
    upd_pc     = pc_for(IDX_W'(5), '0);
    upd_hist   = '0;
    upd_taken  = 1'b1;
    upd_pred   = 1'b0;
    @(negedge clk);
    pred_valid = 1'b0;
    upd_valid  = 1'b0;
    check("R11", "ignored predict during sweep", 32'(pred_out_valid), 32'd0);
    check("R11", "ready during sweep", 32'(ready), 32'd0);
    while (!ready) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) mdl[i] = 2'b01;
    mghr = '0;
    // entry 5 untouched by the ignored update: still weakly not taken
    do_predict(IDX_W'(5), "R1");
  endtask

  // R2, R3
  task automatic t_saturate;
    for (int i = 0; i < 3; i++) do_update(IDX_W'(20), 1'b1, 1'b1, '0);
    do_predict(IDX_W'(20), "R2");
    do_update(IDX_W'(20), 1'b0, 1'b0, '0);
    do_predict(IDX_W'(20), "R3");
    do_update(IDX_W'(20), 1'b0, 1'b0, '0);
    do_predict(IDX_W'(20), "R3");
    for (int i = 0; i < 3; i++) do_update(IDX_W'(20), 1'b0, 1'b0, '0);
    do_update(IDX_W'(20), 1'b1, 1'b1, '0);
    do_predict(IDX_W'(20), "R2");
  endtask

  // R4, R5
  task automatic t_xor_index;
    do_update(IDX_W'(40), 1'b1, 1'b1, '0);
    do_update(IDX_W'(40), 1'b1, 1'b1, '0);
    set_ghr('0);
    do_predict_pc(pc_for(IDX_W'(40), '0), "R4");
    // history is now 1: same PC maps to row 41
    do_predict_pc(pc_for(IDX_W'(40), '0), "R4");
    do_predict_pc(pc_for(IDX_W'(40), mghr) | PC_W'(3), "R5");
  endtask

  // R6
  task automatic t_spec_hist;
    logic [PC_W-1:0]   pc2;
    logic [HIST_W-1:0] h1;
    do_update(IDX_W'(60), 1'b1, 1'b1, '0);
    do_update(IDX_W'(60), 1'b1, 1'b1, '0);
    set_ghr('0);
    pred_valid = 1'b1;
    pred_pc    = pc_for(IDX_W'(40), '0);
    @(negedge clk);
    check("R6", "first taken", 32'(pred_taken), 32'd1);
    check("R6", "first hist", 32'(pred_hist), 32'd0);
    h1  = HIST_W'(1);
    pc2 = pc_for(IDX_W'(60), h1);
    pred_pc = pc2;
    @(negedge clk);
    pred_valid = 1'b0;
    check("R6", "second valid", 32'(pred_out_valid), 32'd1);
    check("R6", "second hist", 32'(pred_hist), 32'(h1));
    check("R6", "second taken", 32'(pred_taken), 32'd1);
    mghr = HIST_W'(3);
    idle(2);
    do_predict(IDX_W'(7), "R6");
  endtask

  // R7
  task automatic t_repair;
    do_update(IDX_W'(70), 1'b1, 1'b1, HIST_W'(8'h55));
    do_predict(IDX_W'(300), "R7");
    do_update(IDX_W'(70), 1'b1, 1'b0, HIST_W'(8'hA3));
    check("R7", "model repair", 32'(mghr), 32'h47);
    do_predict(IDX_W'(300), "R7");
  endtask

  // R8
  task automatic t_same_cycle;
    pred_valid = 1'b1;
    pred_pc    = pc_for(IDX_W'(80), mghr);
    upd_valid  = 1'b1;
    upd_pc     = pc_for(IDX_W'(80), '0);
    upd_hist   = '0;
    upd_taken  = 1'b1;
    upd_pred   = 1'b1;
    @(negedge clk);
    pred_valid = 1'b0;
    upd_valid  = 1'b0;
    check("R8", "pre-update value", 32'(pred_taken), 32'd0);
    mdl[80] = step(mdl[80], 1'b1);
    mghr = {mghr[HIST_W-2:0], 1'b0};
    idle(2);
    do_predict(IDX_W'(80), "R8");
  endtask

  // R9
  task automatic t_repair_predict;
    logic [HIST_W-1:0] hr;
    hr = HIST_W'({8'h0F, 1'b0});
    upd_valid  = 1'b1;
    upd_pc     = pc_for(IDX_W'(1000), HIST_W'(8'h0F));
    upd_hist   = HIST_W'(8'h0F);
    upd_taken  = 1'b0;
    upd_pred   = 1'b1;
    pred_valid = 1'b1;
    pred_pc    = pc_for(IDX_W'(40), hr);
    @(negedge clk);
    upd_valid  = 1'b0;
    pred_valid = 1'b0;
    mdl[1000] = step(mdl[1000], 1'b0);
    check("R9", "hist", 32'(pred_hist), 32'(hr));
    check("R9", "taken", 32'(pred_taken), 32'(mdl[40][1]));
    mghr = {hr[HIST_W-2:0], mdl[40][1]};
    idle(2);
    do_predict(IDX_W'(9), "R9");
  endtask

  // R10
  task automatic t_back_to_back;
    upd_hist = '0;
    upd_pc   = pc_for(IDX_W'(100), '0);
    upd_valid = 1'b1;
    upd_taken = 1'b1; upd_pred = 1'b1;
    @(negedge clk);
    @(negedge clk);
    upd_taken = 1'b0; upd_pred = 1'b0;
    @(negedge clk);
    upd_valid = 1'b0;
    mdl[100] = 2'b10;
    idle(3);
    do_predict(IDX_W'(100), "R10");
  endtask

  initial begin
    rst = 1'b1;
    pred_valid = 1'b0; pred_pc = '0;
    upd_valid = 1'b0; upd_pc = '0; upd_hist = '0; upd_taken = 1'b0; upd_pred = 1'b0;
    mghr = '0;
    @(negedge clk);
    t_reset();
    t_saturate();
    t_xor_index();
    t_spec_hist();
    t_repair();
    t_same_cycle();
    t_repair_predict();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule